// File: doc/BRIEF.md
# DRP Register Access Bridge

This block is a memory-mapped slave. It lets a processor drive the dynamic reconfiguration port (DRP) of a clock tile through a small register window. A single write to the control word starts one DRP transaction. That word carries a start strobe, a read/write choice, the DRP register address and the 16-bit write data. While the transaction is in flight, a busy flag in the status word stays set. When a read completes, the returned data is held in the low half of the status word until the next read completes.

Two more registers drive the tile directly. One holds a block enable bit and a tile-run bit, which releases the clock tile from reset. The other selects which of the input clocks feeds the tile. Software must poll the busy flag before every access, and again after starting a read, before it uses the returned data. A control write that arrives while busy is set is dropped. All registers clear on reset, so the tile starts held in reset with input clock 0 selected.

Top module: `drp_reg_bridge`

## Requirements
- R1: After reset, all outputs and all readable registers are zero: `drp_en`, `blk_en`, `tile_run` and `clk_sel` are 0, and the status word at 0x74 reads 0.
- R2: A bus write to 0x70 with bit 29 set, while busy is clear, drives `drp_en` high for exactly one cycle, starting the cycle after the write. The same write sets status bit 16 (busy) in that cycle. `drp_addr` takes word bits 16 and up, and `drp_di` takes word bits 15:0.
- R3: `drp_we` equals the inverse of control word bit 28: bit 28 = 1 requests a read, and bit 28 = 0 requests a write.
- R4: Busy stays set until `drp_rdy` is sampled high, and reads 0 from the clock edge that samples `drp_rdy`.
- R5: On the ready of a read transaction, `drp_do` is captured into status bits 15:0.
- R6: The ready of a write transaction leaves status bits 15:0 unchanged.
- R7: A write to 0x70 while busy is set is ignored: there is no new `drp_en` pulse, `drp_addr` and `drp_di` are unchanged, and the transaction in flight completes normally.
- R8: A write to 0x70 with bit 29 clear starts no transaction, and busy stays clear.
- R9: Register 0x40 drives `blk_en` from bit 0 and `tile_run` from bit 1, and reads back both bits.
- R10: Register 0x44 holds the input clock index on `clk_sel`, and reads back that index.
- R11: A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| drp_en | output | 1 | DRP enable pulse |
| drp_we | output | 1 | DRP write enable |
| drp_addr | output | 7 | DRP register address |
| drp_di | output | 16 | DRP write data |
| drp_do | input | 16 | DRP read data |
| drp_rdy | input | 1 | DRP ready pulse |
| blk_en | output | 1 | Block enable |
| tile_run | output | 1 | Clock tile out of reset |
| clk_sel | output | 1 | Input clock index |

## Verification
The assertions assume that `drp_rdy` pulses high for exactly one cycle, and only while a transaction is outstanding. They also assume that `drp_do` is valid in the cycle of that pulse. The bench's responder model raises ready only after it has seen `drp_en`, waits a vector-chosen delay of zero to five cycles, and holds ready for a single cycle. For writes, the responder drives `drp_do` with a garbage pattern, so that any capture of data on a write shows up in the status word. Bus writes are single-cycle strobes, driven one time unit after a clock edge.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
  localparam int WORD_W   = 32;
  localparam int START_B  = 29;
  localparam int READ_B   = 28;
  localparam int ADDR_LSB = 16;
  localparam int BUSY_B   = 16;

  localparam logic [7:0] OFS_CFG    = 8'h40;
  localparam logic [7:0] OFS_CLKSEL = 8'h44;
  localparam logic [7:0] OFS_CTRL   = 8'h70;
  localparam logic [7:0] OFS_STAT   = 8'h74;

  function automatic logic word_starts(input logic [WORD_W-1:0] w);
    return w[START_B];
  endfunction

  function automatic logic word_is_read(input logic [WORD_W-1:0] w);
    return w[READ_B];
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic busy,
                                                    input logic [15:0] data);
    logic [WORD_W-1:0] s;
    s = '0;
    s[BUSY_B] = busy;
    s[15:0] = data;
    return s;
  endfunction
endpackage

// File: rtl/drp_cfg_regs.sv
module drp_cfg_regs #(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cfg_bits,
  input  logic [SEL_W-1:0]  sel_bits,
  output logic              blk_en,
  output logic              tile_run,
  output logic [SEL_W-1:0]  clk_sel
);
  import drp_bridge_pkg::*;

  logic cfg_hit, sel_hit;
  assign cfg_hit = wr && (addr == ADDR_W'(OFS_CFG));
  assign sel_hit = wr && (addr == ADDR_W'(OFS_CLKSEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_en   <= 1'b0;
      tile_run <= 1'b0;
      clk_sel  <= '0;
    end else begin
      if (cfg_hit) begin
        blk_en   <= cfg_bits[0];
        tile_run <= cfg_bits[1];
      end
      if (sel_hit) clk_sel <= sel_bits;
    end
  end
endmodule

// File: rtl/drp_txn_seq.sv
module drp_txn_seq #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          drp_rdy,
  input  logic [DW-1:0] drp_do,
  output logic          drp_en,
  output logic          drp_we,
  output logic [AW-1:0] drp_addr,
  output logic [DW-1:0] drp_di,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          accept,
  output logic          done,
  output logic          pend_rd
);
  assign accept = req && !busy;
  assign done   = busy && drp_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drp_en   <= 1'b0;
      drp_we   <= 1'b0;
      drp_addr <= '0;
      drp_di   <= '0;
      busy     <= 1'b0;
      pend_rd  <= 1'b0;
      rd_data  <= '0;
    end else begin
      drp_en <= accept;
      if (accept) begin
        drp_we   <= !req_rd;
        drp_addr <= req_addr;
        drp_di   <= req_data;
        busy     <= 1'b1;
        pend_rd  <= req_rd;
      end else if (done) begin
        busy <= 1'b0;
        if (pend_rd) rd_data <= drp_do;
      end
    end
  end
endmodule

// File: rtl/drp_reg_bridge.sv
module drp_reg_bridge #(
  parameter int ADDR_W  = 8,
  parameter int DRP_AW  = 7,
  parameter int DRP_DW  = 16,
  parameter int NUM_CLK = 2,
  localparam int SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
  localparam int WORD_W = drp_bridge_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  input  logic              drp_rdy,
  output logic              blk_en,
  output logic              tile_run,
  output logic [SEL_W-1:0]  clk_sel
);
  import drp_bridge_pkg::*;

  logic              ctrl_req;
  logic              txn_accept;
  logic              txn_done;
  logic              txn_is_read;
  logic              busy_q;
  logic [DRP_DW-1:0] status_data;
  logic              unused_wbits;

  assign ctrl_req = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && word_starts(bus_wdata);
  assign unused_wbits = ^{bus_wdata[WORD_W-1:START_B+1], bus_wdata[READ_B-1:ADDR_LSB+DRP_AW],
                          bus_wdata[15:DRP_DW > 15 ? 15 : DRP_DW], drp_do};

  drp_cfg_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .cfg_bits (bus_wdata[1:0]),
    .sel_bits (bus_wdata[SEL_W-1:0]),
    .blk_en   (blk_en),
    .tile_run (tile_run),
    .clk_sel  (clk_sel)
  );

  drp_txn_seq #(.AW(DRP_AW), .DW(DRP_DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (ctrl_req),
    .req_rd   (word_is_read(bus_wdata)),
    .req_addr (bus_wdata[ADDR_LSB +: DRP_AW]),
    .req_data (bus_wdata[DRP_DW-1:0]),
    .drp_rdy  (drp_rdy),
    .drp_do   (drp_do),
    .drp_en   (drp_en),
    .drp_we   (drp_we),
    .drp_addr (drp_addr),
    .drp_di   (drp_di),
    .busy     (busy_q),
    .rd_data  (status_data),
    .accept   (txn_accept),
    .done     (txn_done),
    .pend_rd  (txn_is_read)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CFG):    bus_rdata[1:0] = {tile_run, blk_en};
      ADDR_W'(OFS_CLKSEL): bus_rdata[SEL_W-1:0] = clk_sel;
      ADDR_W'(OFS_STAT):   bus_rdata = status_word(busy_q, 16'(status_data));
      default:             bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/drp_reg_bridge_chk.sv
module drp_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_req,
  input logic        busy_q,
  input logic        txn_done,
  input logic        txn_is_read,
  input logic        drp_en,
  input logic        drp_rdy,
  input logic [6:0]  drp_addr,
  input logic [15:0] drp_di,
  input logic [15:0] drp_do,
  input logic [15:0] status_data
);
  AST_EN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en); // R2
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_req && !busy_q) |=> (busy_q && drp_en)); // R2
  AST_READY_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && drp_rdy && !ctrl_req) |=> !busy_q); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !drp_rdy) |=> busy_q); // R4
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && txn_is_read) |=> (status_data == $past(drp_do))); // R5
  AST_WRITE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && !txn_is_read) |=> $stable(status_data)); // R6
  AST_BUSY_IGNORES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ctrl_req) |=> (!drp_en && $stable(drp_addr) && $stable(drp_di))); // R7
endmodule

bind drp_reg_bridge drp_reg_bridge_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_req    (ctrl_req),
  .busy_q      (busy_q),
  .txn_done    (txn_done),
  .txn_is_read (txn_is_read),
  .drp_en      (drp_en),
  .drp_rdy     (drp_rdy),
  .drp_addr    (drp_addr),
  .drp_di      (drp_di),
  .drp_do      (drp_do),
  .status_data (status_data)
);

// File: tb/tb_drp_reg_bridge.sv
module tb_drp_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        drp_en, drp_we, drp_rdy = 1'b0;
  logic [6:0]  drp_addr;
  logic [15:0] drp_di, drp_do = '0;
  logic        blk_en, tile_run;
  logic [0:0]  clk_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  drp_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drp_en(drp_en),
    .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di), .drp_do(drp_do),
    .drp_rdy(drp_rdy), .blk_en(blk_en), .tile_run(tile_run), .clk_sel(clk_sel)
  );

  // vector: {is_read, drp address, data (write data / read response), ready delay}
  localparam logic [27:0] VEC [5] = '{
    {1'b0, 7'h08, 16'h1234, 4'd0},
    {1'b1, 7'h16, 16'hBEEF, 4'd2},
    {1'b0, 7'h4E, 16'h9900, 4'd3},
    {1'b1, 7'h7F, 16'h0001, 4'd1},
    {1'b0, 7'h00, 16'hFFFF, 4'd5}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input bit go, input bit rd, input logic [6:0] a,
                                            input logic [15:0] d);
    return (32'(go) << 29) | (32'(rd) << 28) | (32'(a) << 16) | 32'(d);
  endfunction

  task automatic pulse_ready(input logic [15:0] d);
    drp_do = d; drp_rdy = 1'b1;
    @(posedge clk); #1;
    drp_rdy = 1'b0; drp_do = 16'h0000;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk(drp_en == 0 && blk_en == 0 && tile_run == 0 && clk_sel == 0, "R1 outputs",
        {drp_en, blk_en, tile_run, clk_sel}, 0);
    bus_read(8'h74, r); chk(r == 0, "R1 status", r, 0);
    rst_n = 1'b1;

    // R9 config register
    bus_write(8'h40, 32'h3);
    chk(blk_en == 1 && tile_run == 1, "R9 outputs", {blk_en, tile_run}, 2'b11);
    bus_read(8'h40, r); chk(r == 32'h3, "R9 readback", r, 32'h3);
    bus_write(8'h40, 32'h2);
    chk(blk_en == 0 && tile_run == 1, "R9 partial", {blk_en, tile_run}, 2'b01);
    // R10 clock select
    bus_write(8'h44, 32'h1);
    chk(clk_sel == 1, "R10 output", clk_sel, 1);
    bus_read(8'h44, r); chk(r == 32'h1, "R10 readback", r, 1);
    // R11 unmapped
    bus_read(8'h48, r); chk(r == 0, "R11 unmapped", r, 0);

    // R8 start bit clear
    bus_write(8'h70, ctrl_word(0, 1, 7'h11, 16'hAAAA));
    chk(drp_en == 0, "R8 no pulse", drp_en, 0);
    bus_read(8'h74, r); chk(r[16] == 0, "R8 not busy", r, 0);

    // table of transactions: R2 R3 R4 R5 R6
    held = 16'h0000;
    for (int i = 0; i < 5; i++) begin
      bit rd = VEC[i][27];
      logic [6:0] a = VEC[i][26:20];
      logic [15:0] d = VEC[i][19:4];
      int dly = int'(VEC[i][3:0]);
      bus_write(8'h70, ctrl_word(1, rd, a, d));
      chk(drp_en == 1, "R2 enable pulse", drp_en, 1);
      chk(drp_addr == a && drp_di == d, "R2 addr/data", {drp_addr, drp_di}, {a, d});
      chk(drp_we == !rd, "R3 write enable", drp_we, !rd);
      bus_read(8'h74, r); chk(r[16] == 1, "R2 busy set", r, 32'h10000);
      for (int k = 0; k < dly; k++) begin
        @(posedge clk); #1;
        chk(drp_en == 0, "R2 single pulse", drp_en, 0);
        bus_read(8'h74, r); chk(r[16] == 1, "R4 busy held", r, 32'h10000);
      end
      pulse_ready(rd ? d : 16'hDEAD);
      if (rd) held = d;
      bus_read(8'h74, r);
      chk(r == {15'b0, 1'b0, held}, rd ? "R5 read capture" : "R6 write keeps data",
          r, {16'b0, held});
    end

    // R7 control write while busy is ignored
    bus_write(8'h70, ctrl_word(1, 1, 7'h10, 16'h0000));
    bus_write(8'h70, ctrl_word(1, 0, 7'h20, 16'hCCCC));
    chk(drp_en == 0, "R7 no second pulse", drp_en, 0);
    chk(drp_addr == 7'h10 && drp_di == 16'h0000, "R7 addr kept", {drp_addr, drp_di}, {7'h10, 16'h0});
    pulse_ready(16'h5A5A);
    bus_read(8'h74, r); chk(r == 32'h0000_5A5A, "R7 first txn completes", r, 32'h5A5A);
    @(posedge clk); #1;
    chk(drp_en == 0, "R7 nothing queued", drp_en, 0);
    bus_read(8'h74, r); chk(r[16] == 0, "R7 idle after", r, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule